// File: doc/BRIEF.md
# Normalized Complex Ratio Unit

This block forms the complex ratio of a measured phasor to a reference phasor. Four signed correlation sums come in: the reference real and imaginary parts and the measured real and imaginary parts. The block returns the real and imaginary parts of measured/reference in signed Q16.16 fixed point. The sums are captured when `start_i` is accepted. A one-cycle `done_o` marks the moment the new result appears on the outputs.

The conjugate-multiply form is not used. Every operand is first divided by the reference real part, which keeps the intermediate values in a narrow range. The two normalized numerators are then divided by one plus the square of the normalized reference imaginary part. A single sequential restoring divider performs all five divisions, one after another. A zero reference real part is not divided at all: the result is flagged as an error.

Top module: `cplx_ratio_unit`

## Requirements
- R1: With rr, ri, mr, mi the reference real and imaginary parts and the measured real and imaginary parts, the result follows this sequence, where every division is one quotient q(x,d). First a = q(ri,rr), b = q(mr,rr) and c = q(mi,rr). Then den = ((a·a)>>>16) + 65536, nre = b + ((c·a)>>>16) and nim = c − ((b·a)>>>16). Finally gamma_re_o = q(nre,den) and gamma_im_o = q(nim,den).
- R2: The quotient q(x,d) is (x·65536)/d, truncated toward zero and clamped to the range [−2^31, 2^31−1]. Every product p is taken as the arithmetic right shift p>>>16. Both outputs are 32-bit two's complement values in Q16.16.
- R3: A `start_i` sampled while `busy_o` is low and `ref_re_i` is nonzero is accepted, and `busy_o` is high from the next cycle until the result is delivered.
- R4: `done_o` is high for exactly one cycle per accepted start. `gamma_re_o`, `gamma_im_o` and `err_o` change only in that cycle and hold their values otherwise.
- R5: When an accepted start has `ref_re_i` equal to zero, `done_o` rises in the next cycle with `err_o` = 1 and both outputs equal to 0, and `busy_o` stays low.
- R6: A valid result clears `err_o` to 0.
- R7: A `start_i` that arrives while `busy_o` is high is ignored: it produces no extra `done_o` and does not alter the pending result.
- R8: The operands are captured at the accepted start. Input changes while busy do not affect the result.
- R9: A valid result arrives at most 400 cycles after the accepted start, well under 50 us at 125 MHz.
- R10: After reset `busy_o`, `done_o` and `err_o` are 0 and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a computation |
| ref_re_i | input | 48 | Reference real sum, signed |
| ref_im_i | input | 48 | Reference imaginary sum, signed |
| meas_re_i | input | 48 | Measured real sum, signed |
| meas_im_i | input | 48 | Measured imaginary sum, signed |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Reference real part was zero |
| gamma_re_o | output | 32 | Ratio real part, Q16.16 |
| gamma_im_o | output | 32 | Ratio imaginary part, Q16.16 |

## Verification
The assertions watch every cycle for the following:
- acceptance raising `busy_o`;
- the single-cycle error response and its zeroed outputs;
- outputs holding between strobes;
- the divider never being started with a zero divisor.

Only the bench's scenarios can show the numerical correctness of the fixed-point chain. Those scenarios cover negative and huge reference values, saturating quotients, the pure-imaginary and unity ratios, and the latency bound. They also show that starts and input changes during a computation leave the pending result untouched.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIV_A,
    ST_DIV_B,
    ST_DIV_C,
    ST_MIX,
    ST_DIV_RE,
    ST_DIV_IM
  } seq_e;

  function automatic int imax(input int x, input int y);
    return (x > y) ? x : y;
  endfunction
endpackage

// File: rtl/cdiv_qmul.sv
module cdiv_qmul #(
  parameter int OP_W  = 32,
  parameter int FRAC  = 16,
  parameter int RES_W = 49
) (
  input  logic signed [OP_W-1:0]  a_i,
  input  logic signed [OP_W-1:0]  b_i,
  output logic signed [RES_W-1:0] y_o
);
  localparam int P_W = 2 * OP_W;

  logic signed [P_W-1:0] prod;

  assign prod = P_W'(a_i) * P_W'(b_i);
  assign y_o  = RES_W'(prod >>> FRAC);
endmodule

// File: rtl/cdiv_rdiv.sv
module cdiv_rdiv #(
  parameter int NUM_W = 65,
  parameter int DEN_W = 49,
  parameter int Q_W   = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic signed [NUM_W-1:0] dividend_i,
  input  logic signed [DEN_W-1:0] divisor_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic signed [Q_W-1:0]   quot_o
);
  localparam int CNT_W = $clog2(NUM_W);
  localparam logic [NUM_W-1:0] POS_LIM = {{(NUM_W-Q_W+1){1'b0}}, {(Q_W-1){1'b1}}};
  localparam logic [NUM_W-1:0] NEG_LIM = {{(NUM_W-Q_W){1'b0}}, 1'b1, {(Q_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(NUM_W - 1);

  logic [DEN_W-1:0] rem_q, dmag_q;
  logic [NUM_W-1:0] num_q;
  logic [CNT_W-1:0] cnt_q;
  logic             neg_q, busy_q, done_q;
  logic signed [Q_W-1:0] quot_q;

  logic [NUM_W-1:0] dnd_mag;
  logic [DEN_W-1:0] dvs_mag;
  logic [DEN_W:0]   trial;
  logic             fits;
  logic [DEN_W-1:0] diff, rem_nx;
  logic [NUM_W-1:0] qmag_nx;
  logic signed [Q_W-1:0] q_sat;

  assign dnd_mag = dividend_i[NUM_W-1] ? NUM_W'(-dividend_i) : NUM_W'(dividend_i);
  assign dvs_mag = divisor_i[DEN_W-1]  ? DEN_W'(-divisor_i)  : DEN_W'(divisor_i);

  always_comb begin
    trial   = {rem_q, num_q[NUM_W-1]};
    fits    = trial >= {1'b0, dmag_q};
    diff    = trial[DEN_W-1:0] - dmag_q;
    rem_nx  = fits ? diff : trial[DEN_W-1:0];
    qmag_nx = {num_q[NUM_W-2:0], fits};
    if (!neg_q) begin
      q_sat = (qmag_nx > POS_LIM) ? signed'(POS_LIM[Q_W-1:0]) : signed'(qmag_nx[Q_W-1:0]);
    end else begin
      q_sat = (qmag_nx > NEG_LIM) ? signed'(NEG_LIM[Q_W-1:0]) : -signed'(qmag_nx[Q_W-1:0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      dmag_q <= '0;
      num_q  <= '0;
      cnt_q  <= '0;
      neg_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      quot_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        rem_q  <= '0;
        num_q  <= dnd_mag;
        dmag_q <= dvs_mag;
        neg_q  <= dividend_i[NUM_W-1] ^ divisor_i[DEN_W-1];
        cnt_q  <= LAST_C;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= rem_nx;
        num_q <= qmag_nx;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          quot_q <= q_sat;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quot_o = quot_q;

  // R5
  div_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> divisor_i != '0);
  // R9
  div_done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));
endmodule

// File: rtl/cplx_ratio_unit.sv
module cplx_ratio_unit
  import cdiv_pkg::*;
#(
  parameter int IN_W  = 48,
  parameter int OUT_W = 32,
  parameter int FRAC  = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic signed [IN_W-1:0]  ref_re_i,
  input  logic signed [IN_W-1:0]  ref_im_i,
  input  logic signed [IN_W-1:0]  meas_re_i,
  input  logic signed [IN_W-1:0]  meas_im_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    err_o,
  output logic signed [OUT_W-1:0] gamma_re_o,
  output logic signed [OUT_W-1:0] gamma_im_o
);
  // internal width holds inputs and Q products with one guard bit
  localparam int X_W   = imax(IN_W, 2 * OUT_W - FRAC) + 1;
  localparam int NUM_W = X_W + FRAC;
  localparam logic signed [X_W-1:0] ONE_Q = X_W'(1) <<< FRAC;

  seq_e state_q;
  logic signed [X_W-1:0]   rc_q, sc_q, ss_q;
  logic signed [OUT_W-1:0] a_q, b_q, c_q, re_q;
  logic signed [X_W-1:0]   den_q, nim_q;
  logic signed [NUM_W-1:0] dnd_q;
  logic signed [X_W-1:0]   dvs_q;
  logic                    go_q, done_q, err_q;
  logic signed [OUT_W-1:0] gre_q, gim_q;

  logic                    div_busy, div_done;
  logic signed [OUT_W-1:0] div_q;
  logic signed [X_W-1:0]   p_aa, p_ca, p_ba;
  logic signed [X_W-1:0]   den_c, nre_c, nim_c;

  cdiv_qmul #(.OP_W(OUT_W), .FRAC(FRAC), .RES_W(X_W)) u_aa (.a_i(a_q), .b_i(a_q), .y_o(p_aa));
  cdiv_qmul #(.OP_W(OUT_W), .FRAC(FRAC), .RES_W(X_W)) u_ca (.a_i(c_q), .b_i(a_q), .y_o(p_ca));
  cdiv_qmul #(.OP_W(OUT_W), .FRAC(FRAC), .RES_W(X_W)) u_ba (.a_i(b_q), .b_i(a_q), .y_o(p_ba));

  assign den_c = p_aa + ONE_Q;
  assign nre_c = X_W'(b_q) + p_ca;
  assign nim_c = X_W'(c_q) - p_ba;

  cdiv_rdiv #(.NUM_W(NUM_W), .DEN_W(X_W), .Q_W(OUT_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (go_q),
    .dividend_i (dnd_q),
    .divisor_i  (dvs_q),
    .busy_o     (div_busy),
    .done_o     (div_done),
    .quot_o     (div_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rc_q  <= '0;
      sc_q  <= '0;
      ss_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      c_q   <= '0;
      re_q  <= '0;
      den_q <= '0;
      nim_q <= '0;
      dnd_q <= '0;
      dvs_q <= '0;
      go_q  <= 1'b0;
      done_q <= 1'b0;
      err_q <= 1'b0;
      gre_q <= '0;
      gim_q <= '0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (ref_re_i == '0) begin
            err_q  <= 1'b1;
            gre_q  <= '0;
            gim_q  <= '0;
            done_q <= 1'b1;
          end else begin
            rc_q  <= X_W'(ref_re_i);
            sc_q  <= X_W'(meas_re_i);
            ss_q  <= X_W'(meas_im_i);
            dnd_q <= {X_W'(ref_im_i), FRAC'(0)};
            dvs_q <= X_W'(ref_re_i);
            go_q  <= 1'b1;
            state_q <= ST_DIV_A;
          end
        end
        ST_DIV_A: if (div_done) begin
          a_q   <= div_q;
          dnd_q <= {sc_q, FRAC'(0)};
          dvs_q <= rc_q;
          go_q  <= 1'b1;
          state_q <= ST_DIV_B;
        end
        ST_DIV_B: if (div_done) begin
          b_q   <= div_q;
          dnd_q <= {ss_q, FRAC'(0)};
          dvs_q <= rc_q;
          go_q  <= 1'b1;
          state_q <= ST_DIV_C;
        end
        ST_DIV_C: if (div_done) begin
          c_q     <= div_q;
          state_q <= ST_MIX;
        end
        ST_MIX: begin
          den_q <= den_c;
          nim_q <= nim_c;
          dnd_q <= {nre_c, FRAC'(0)};
          dvs_q <= den_c;
          go_q  <= 1'b1;
          state_q <= ST_DIV_RE;
        end
        ST_DIV_RE: if (div_done) begin
          re_q  <= div_q;
          dnd_q <= {nim_q, FRAC'(0)};
          dvs_q <= den_q;
          go_q  <= 1'b1;
          state_q <= ST_DIV_IM;
        end
        ST_DIV_IM: if (div_done) begin
          gre_q  <= re_q;
          gim_q  <= div_q;
          err_q  <= 1'b0;
          done_q <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = state_q != ST_IDLE;
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign gamma_re_o = gre_q;
  assign gamma_im_o = gim_q;

  // R3
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && ref_re_i != '0 |=> busy_o);
  // R5
  zero_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && ref_re_i == '0 |=> done_o && err_o && !busy_o);
  // R5
  err_zero_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> gamma_re_o == '0 && gamma_im_o == '0);
  // R4
  hold_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(gamma_re_o) && $stable(gamma_im_o) && $stable(err_o));
  // R7
  div_idle_at_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !div_busy);
endmodule

// File: tb/cplx_ratio_unit_bench.sv
module cplx_ratio_unit_bench;
  localparam time CLK_P = 8ns;
  localparam longint QMAX = 64'sd2147483647;
  localparam longint QMIN = -64'sd2147483648;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic signed [47:0] ref_re = '0, ref_im = '0, meas_re = '0, meas_im = '0;
  logic busy, done, err;
  logic signed [31:0] g_re, g_im;

  always #(CLK_P / 2) clk = ~clk;

  cplx_ratio_unit u_cplx_ratio_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .ref_re_i(ref_re), .ref_im_i(ref_im), .meas_re_i(meas_re), .meas_im_i(meas_im),
    .busy_o(busy), .done_o(done), .err_o(err), .gamma_re_o(g_re), .gamma_im_o(g_im)
  );

  int n_chk = 0, n_fail = 0;
  bit ended = 0;
  longint cyc = 0;
  longint exp_re_q[$], exp_im_q[$], st_cyc_q[$];
  bit exp_err_q[$];
  string exp_tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic longint qdiv(input longint x, input longint d);
    longint q;
    q = (x <<< 16) / d;
    if (q > QMAX) q = QMAX;
    if (q < QMIN) q = QMIN;
    return q;
  endfunction

  // R1 R2 model
  task automatic model(input longint rr, ri, mr, mi, output longint re, im);
    longint a, b, c, den, nre, nim;
    a = qdiv(ri, rr);
    b = qdiv(mr, rr);
    c = qdiv(mi, rr);
    den = ((a * a) >>> 16) + 65536;
    nre = b + ((c * a) >>> 16);
    nim = c - ((b * a) >>> 16);
    re = qdiv(nre, den);
    im = qdiv(nim, den);
  endtask

  // monitor / scoreboard
  bit prev_done = 0, have_prev = 0;
  longint last_re = 0, last_im = 0;
  bit last_err = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (exp_re_q.size() == 0) begin
          chk(0, "R7", "unexpected done", 1, 0);
        end else begin
          longint er, ei, sc, lat;
          bit ee;
          string tg;
          er = exp_re_q.pop_front();
          ei = exp_im_q.pop_front();
          ee = exp_err_q.pop_front();
          tg = exp_tag_q.pop_front();
          sc = st_cyc_q.pop_front();
          lat = cyc - sc;
          chk(longint'(g_re) == er, "R1", {tg, " re"}, g_re, er);
          chk(longint'(g_im) == ei, "R1", {tg, " im"}, g_im, ei);
          chk(err == ee, ee ? "R5" : "R6", {tg, " err"}, err, ee);
          if (ee) chk(lat == 1, "R5", {tg, " latency"}, lat, 1);
          else chk(lat <= 400, "R9", {tg, " latency"}, lat, 400);
          chk(!busy, "R4", {tg, " busy at done"}, busy, 0);
        end
        chk(!prev_done, "R4", "done width", 2, 1);
      end else if (have_prev) begin
        chk(g_re == last_re && g_im == last_im && err == last_err, "R4",
            "hold between strobes", g_re, last_re);
      end
      prev_done = done;
      have_prev = 1;
      last_re = g_re;
      last_im = g_im;
      last_err = err;
    end
  end

  task automatic run_op(input longint rr, ri, mr, mi, input string tag, input bit poke);
    longint er, ei;
    if (rr == 0) begin
      er = 0; ei = 0;
    end else begin
      model(rr, ri, mr, mi, er, ei);
    end
    @(negedge clk);
    exp_re_q.push_back(er);
    exp_im_q.push_back(ei);
    exp_err_q.push_back(rr == 0);
    exp_tag_q.push_back(tag);
    st_cyc_q.push_back(cyc);
    ref_re = rr[47:0]; ref_im = ri[47:0]; meas_re = mr[47:0]; meas_im = mi[47:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (rr != 0) chk(busy, "R3", {tag, " busy after start"}, busy, 1);
    else chk(!busy, "R5", {tag, " busy on zero ref"}, busy, 0);
    if (poke) begin
      repeat (5) @(negedge clk);
      // R7 R8: new operands and a start while busy
      ref_re = 48'sd77; ref_im = -48'sd5000; meas_re = 48'sd123456; meas_im = 48'sd9;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      ref_re = 48'sd1; ref_im = 48'sd1; meas_re = 48'sd1; meas_im = 48'sd1;
    end
    while (exp_re_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    chk(0, "R9", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy && !done && !err, "R10", "flags in reset", {busy, done, err}, 0);
    chk(g_re == 0 && g_im == 0, "R10", "outputs in reset", g_re, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R10", "flags after reset", {busy, done}, 0);

    run_op(1000000, 0, 500000, 0, "half", 0);
    run_op(3 <<< 20, 4 <<< 20, 3 <<< 20, 4 <<< 20, "unity", 0);
    run_op(123456, -78901, 78901, 123456, "pure_j", 0);
    run_op(-2000000, 700000, 1500000, -900000, "neg_ref", 0);
    run_op(0, 5, 6, 7, "zero_ref", 0);
    run_op(987654, 12345, -54321, 11111, "after_err", 0);
    run_op(1, 0, 64'sd1 <<< 40, 0, "sat_b", 0);
    run_op(5, 1000000, 3000, -4000, "sat_a", 0);
    run_op(64'sd1 <<< 46, -(64'sd1 <<< 46), 64'sd1 <<< 45, 64'sd1 <<< 44, "wide", 0);
    run_op(0, 0, 0, 0, "zero_again", 0);
    run_op(-(64'sd1 <<< 47), 64'sd3 <<< 40, -(64'sd1 <<< 44), 64'sd7, "min_ref", 0);
    run_op(250000, -30000, 40000, 90000, "poke", 1);
    for (int k = 0; k < 6; k++) begin
      longint rr, ri, mr, mi;
      rr = longint'($signed($urandom)) <<< ($urandom % 12);
      ri = longint'($signed($urandom)) <<< ($urandom % 12);
      mr = longint'($signed($urandom)) <<< ($urandom % 12);
      mi = longint'($signed($urandom)) <<< ($urandom % 12);
      if (rr == 0) rr = 17;
      run_op(rr, ri, mr, mi, "rand", 0);
    end
    chk(exp_re_q.size() == 0, "R7", "results outstanding", exp_re_q.size(), 0);
    summary();
  end
endmodule